// File: doc/BRIEF.md
# Thermometer Ramp Switch Driver

This block turns a shared converter's phase command and column counter into the switch control words of a 12-bit capacitor ramp DAC. The DAC is built from two unary arrays of 63 unit capacitors each, joined by an attenuation capacitor. The driver forms a 12-bit code for the present phase and splits it into a low 6-bit field and a high 6-bit field. It expands each field into a thermometer word, so that field value v closes exactly the switches 0 to v-1 of its array. Because of this, the ramp can only move in one direction while the counter climbs. Between neighbouring codes only one switch moves, except where the low field rolls over.

Four commands select the phase. Idle opens every switch. Coarse hold parks the ramp at positive full scale while the columns step through their references. Fine ramp starts one extension step below the top reference and adds the counter value to it. When the sum reaches full scale, the driver latches a done state and stays there for as long as the fine command remains. Test level outputs the fixed code for the middle of subsection m, which is used to calibrate the reference offsets.

The FSM states are ST_IDLE, ST_HOLD, ST_RAMP, ST_DONE and ST_TEST. Every cycle the command selects the next state. Command idle goes to ST_IDLE, hold to ST_HOLD and test to ST_TEST. Command fine goes to ST_DONE if the present state is ST_DONE or if start plus count is at least full scale; otherwise it goes to ST_RAMP. The switch words, the code and the active flag are registered, so every switch changes on the same clock edge.

Top module: `ramp_switch_driver`

## Requirements
- R1: The 12-bit code splits into a low field (bits 5..0) that drives lsb_sw_o and a high field (bits 11..6) that drives msb_sw_o. For a field value v, bit i of its 63-bit word is 1 exactly when i < v.
- R2: The outputs change one rising edge after the inputs are sampled. While rst_n is low (active-low reset), both switch words are zero and ramp_active_o is 0.
- R3: Command 2'b00 (idle) gives code 0: both words are all zeros.
- R4: Command 2'b01 (coarse hold) gives code 4095: both words are all ones, and ramp_active_o is 0.
- R5: Command 2'b10 (fine ramp) gives code 3520 + count_i. 3520 is the top reference 7*512 minus an extension of 64. ramp_active_o is 1 while that sum is below 4095.
- R6: When the fine sum reaches or passes 4095, the driver enters ST_DONE. It then outputs code 4095 with ramp_active_o at 0, and keeps doing so while the command stays 2'b10, even if count_i falls.
- R7: Command 2'b11 (test level) gives code m*512 + 256, where m is test_idx_i. ramp_active_o is 0.
- R8: When the code rises by one, exactly one switch toggles. The exception is when the low field goes from 63 to 0: then all 63 low switches open and exactly one more high switch closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 2 | Phase command: 00 idle, 01 coarse hold, 10 fine ramp, 11 test level |
| count_i | input | 10 | Fine-phase counter value |
| test_idx_i | input | 3 | Subsection index m for test level |
| lsb_sw_o | output | 63 | Thermometer switch word, low array |
| msb_sw_o | output | 63 | Thermometer switch word, high array |
| ramp_active_o | output | 1 | High while the fine ramp is below full scale |

## Verification
The assertions check several things on every cycle. Both words always have thermometer form. Idle means all switches open, and hold means all switches closed. The active flag is only ever high in ST_RAMP. ST_DONE persists under the fine command. Any unit code step moves a single switch or forms a clean low-field wrap. The exact code values cannot be shown by the assertions and are left to the bench scenarios: the ramp start offset, the placement of the test levels, the saturation point, the one-edge latency and the reset values. The bench also runs a full counter sweep that shows the single-toggle property across every wrap of a real ramp.

// File: rtl/ramp_drv_pkg.sv
package ramp_drv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_RAMP,
        ST_DONE,
        ST_TEST
    } drv_state_t;

    localparam logic [1:0] CMD_IDLE = 2'b00;
    localparam logic [1:0] CMD_HOLD = 2'b01;
    localparam logic [1:0] CMD_RAMP = 2'b10;
    localparam logic [1:0] CMD_TEST = 2'b11;

endpackage

// File: rtl/therm_encoder.sv
module therm_encoder #(
    parameter int BIN_W = 6
) (
    input  logic [BIN_W-1:0]        bin_i,
    output logic [(1<<BIN_W)-2:0]   therm_o
);
    localparam int TW = (1 << BIN_W) - 1;

    // Each unit switch closes when the field value exceeds its index.
    for (genvar i = 0; i < TW; i++) begin : g_unit
        assign therm_o[i] = (bin_i > BIN_W'(i));
    end
endmodule

// File: rtl/ramp_code_gen.sv
module ramp_code_gen
    import ramp_drv_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int CRS_W  = 3,
    parameter int CNT_W  = 10,
    parameter int EXT    = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cmd_i,
    input  logic [CNT_W-1:0]    count_i,
    input  logic [CRS_W-1:0]    test_idx_i,
    output drv_state_t          state_o,
    output logic [CODE_W-1:0]   code_o,
    output logic                active_o
);
    localparam int Q       = CODE_W - CRS_W;
    localparam int SUM_W   = CODE_W + 1;
    localparam int FULL    = (1 << CODE_W) - 1;
    localparam int TOP_REF = ((1 << CRS_W) - 1) << Q;
    localparam int START   = TOP_REF - EXT;

    drv_state_t        state_q, state_d;
    logic [SUM_W-1:0]  sum;
    logic [CODE_W-1:0] test_code;

    assign sum       = SUM_W'(START) + SUM_W'(count_i);
    assign test_code = {test_idx_i, 1'b1, {(Q-1){1'b0}}};

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (cmd_i)
            CMD_IDLE: state_d = ST_IDLE;
            CMD_HOLD: state_d = ST_HOLD;
            CMD_TEST: state_d = ST_TEST;
            CMD_RAMP: begin
                if (state_q == ST_DONE || sum >= SUM_W'(FULL))
                    state_d = ST_DONE;
                else
                    state_d = ST_RAMP;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Code and flag for the state being entered
    always_comb begin
        code_o   = '0;
        active_o = 1'b0;
        unique case (state_d)
            ST_IDLE: code_o = '0;
            ST_HOLD: code_o = CODE_W'(FULL);
            ST_DONE: code_o = CODE_W'(FULL);
            ST_RAMP: begin
                code_o   = sum[CODE_W-1:0];
                active_o = 1'b1;
            end
            ST_TEST: code_o = test_code;
            default: code_o = '0;
        endcase
    end

    assign state_o = state_q;

    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && cmd_i == CMD_RAMP) |=> (state_q == ST_DONE));

endmodule

// File: rtl/ramp_switch_driver.sv
module ramp_switch_driver
    import ramp_drv_pkg::*;
#(
    parameter int LSB_W = 6,
    parameter int MSB_W = 6,
    parameter int CRS_W = 3,
    parameter int CNT_W = 10,
    parameter int EXT   = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  cmd_i,
    input  logic [CNT_W-1:0]            count_i,
    input  logic [CRS_W-1:0]            test_idx_i,
    output logic [(1<<LSB_W)-2:0]       lsb_sw_o,
    output logic [(1<<MSB_W)-2:0]       msb_sw_o,
    output logic                        ramp_active_o
);
    localparam int CODE_W = LSB_W + MSB_W;
    localparam int LTW    = (1 << LSB_W) - 1;
    localparam int MTW    = (1 << MSB_W) - 1;

    drv_state_t         state;
    logic [CODE_W-1:0]  code_d, code_q;
    logic               active_d;
    logic [LTW-1:0]     lsb_d;
    logic [MTW-1:0]     msb_d;

    ramp_code_gen #(
        .CODE_W (CODE_W),
        .CRS_W  (CRS_W),
        .CNT_W  (CNT_W),
        .EXT    (EXT)
    ) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd_i),
        .count_i    (count_i),
        .test_idx_i (test_idx_i),
        .state_o    (state),
        .code_o     (code_d),
        .active_o   (active_d)
    );

    therm_encoder #(.BIN_W(LSB_W)) u_lsb_enc (
        .bin_i   (code_d[LSB_W-1:0]),
        .therm_o (lsb_d)
    );

    therm_encoder #(.BIN_W(MSB_W)) u_msb_enc (
        .bin_i   (code_d[CODE_W-1:LSB_W]),
        .therm_o (msb_d)
    );

    // All switches update together on one edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lsb_sw_o      <= '0;
            msb_sw_o      <= '0;
            ramp_active_o <= 1'b0;
            code_q        <= '0;
        end else begin
            lsb_sw_o      <= lsb_d;
            msb_sw_o      <= msb_d;
            ramp_active_o <= active_d;
            code_q        <= code_d;
        end
    end

    // R1
    therm_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lsb_sw_o & (lsb_sw_o + LTW'(1))) == '0) &&
        ((msb_sw_o & (msb_sw_o + MTW'(1))) == '0));

    // R3
    idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (lsb_sw_o == '0 && msb_sw_o == '0));

    // R4
    hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> ((&lsb_sw_o) && (&msb_sw_o) && !ramp_active_o));

    // R5
    active_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_active_o |-> (state == ST_RAMP));

    // R8
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, code_q} == {1'b0, $past(code_q)} + (CODE_W+1)'(1)) |->
        ((($countones(lsb_sw_o ^ $past(lsb_sw_o)) == 1) && $stable(msb_sw_o)) ||
         ((&$past(lsb_sw_o)) && lsb_sw_o == '0 &&
          ($countones(msb_sw_o ^ $past(msb_sw_o)) == 1))));

endmodule

// File: tb/ramp_switch_driver_test.sv
module ramp_switch_driver_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd_i = 2'b00;
    logic [9:0]  count_i = '0;
    logic [2:0]  test_idx_i = '0;
    logic [62:0] lsb_sw_o, msb_sw_o;
    logic        ramp_active_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ramp_switch_driver uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_i         (cmd_i),
        .count_i       (count_i),
        .test_idx_i    (test_idx_i),
        .lsb_sw_o      (lsb_sw_o),
        .msb_sw_o      (msb_sw_o),
        .ramp_active_o (ramp_active_o)
    );

    // {cmd, count, idx, msb level, lsb level, active}
    typedef struct packed {
        logic [1:0] cmd;
        logic [9:0] cnt;
        logic [2:0] idx;
        logic [6:0] msb;
        logic [6:0] lsb;
        logic       act;
    } vec_t;

    localparam vec_t VECS [14] = '{
        '{2'b01, 10'd0,   3'd0, 7'd63, 7'd63, 1'b0},  // R4 hold
        '{2'b10, 10'd0,   3'd0, 7'd55, 7'd0,  1'b1},  // R5 start 3520
        '{2'b10, 10'd1,   3'd0, 7'd55, 7'd1,  1'b1},  // R5
        '{2'b10, 10'd63,  3'd0, 7'd55, 7'd63, 1'b1},  // R1 low field full
        '{2'b10, 10'd64,  3'd0, 7'd56, 7'd0,  1'b1},  // R1 wrap
        '{2'b10, 10'd574, 3'd0, 7'd63, 7'd62, 1'b1},  // R5 last active
        '{2'b10, 10'd575, 3'd0, 7'd63, 7'd63, 1'b0},  // R6 saturate
        '{2'b10, 10'd10,  3'd0, 7'd63, 7'd63, 1'b0},  // R6 sticky
        '{2'b11, 10'd0,   3'd0, 7'd4,  7'd0,  1'b0},  // R7 m=0
        '{2'b11, 10'd0,   3'd7, 7'd60, 7'd0,  1'b0},  // R7 m=7
        '{2'b11, 10'd0,   3'd3, 7'd28, 7'd0,  1'b0},  // R7 m=3
        '{2'b00, 10'd0,   3'd0, 7'd0,  7'd0,  1'b0},  // R3 idle
        '{2'b10, 10'd100, 3'd0, 7'd56, 7'd36, 1'b1},  // R5 from idle
        '{2'b01, 10'd9,   3'd0, 7'd63, 7'd63, 1'b0}   // R4 hold again
    };

    function automatic logic [62:0] therm(input int n);
        logic [62:0] r;
        for (int i = 0; i < 63; i++) r[i] = (i < n);
        return r;
    endfunction

    task automatic check(input string req, input logic [62:0] em, input logic [62:0] el,
                         input logic ea);
        checks++;
        if (msb_sw_o !== em || lsb_sw_o !== el || ramp_active_o !== ea) begin
            fails++;
            $display("FAIL %s: msb=%h lsb=%h act=%b expected msb=%h lsb=%h act=%b",
                     req, msb_sw_o, lsb_sw_o, ramp_active_o, em, el, ea);
        end
    endtask

    task automatic apply(input logic [1:0] c, input logic [9:0] n, input logic [2:0] m);
        @(negedge clk);
        cmd_i = c; count_i = n; test_idx_i = m;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        logic [62:0] pl, pm;
        // R2 reset state
        repeat (3) @(posedge clk);
        #1 check("R2 reset", '0, '0, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        // R2 one-edge latency
        @(negedge clk) cmd_i = 2'b01;
        #1 check("R2 before edge", '0, '0, 1'b0);
        @(posedge clk) #1 check("R2 after edge", therm(63), therm(63), 1'b0);

        foreach (VECS[k]) begin
            apply(VECS[k].cmd, VECS[k].cnt, VECS[k].idx);
            check($sformatf("R1/R3-R7 vector %0d", k),
                  therm(int'(VECS[k].msb)), therm(int'(VECS[k].lsb)), VECS[k].act);
        end

        // R8 full fine sweep
        apply(2'b01, 10'd0, 3'd0);
        apply(2'b10, 10'd0, 3'd0);
        for (int n = 1; n <= 575; n++) begin
            pl = lsb_sw_o; pm = msb_sw_o;
            apply(2'b10, 10'(n), 3'd0);
            checks++;
            if (&pl) begin
                if (lsb_sw_o !== '0 || $countones(msb_sw_o ^ pm) != 1 || (msb_sw_o & pm) !== pm) begin
                    fails++;
                    $display("FAIL R8 wrap at %0d: lsb=%h msb=%h expected lsb=0 msb=%h plus one bit",
                             n, lsb_sw_o, msb_sw_o, pm);
                end
            end else if ($countones({lsb_sw_o ^ pl, msb_sw_o ^ pm}) != 1) begin
                fails++;
                $display("FAIL R8 step at %0d: toggles=%0d expected 1",
                         n, $countones({lsb_sw_o ^ pl, msb_sw_o ^ pm}));
            end
        end
        check("R6 sweep end", therm(63), therm(63), 1'b0);

        // R6 leaving done via hold then re-entering ramp
        apply(2'b01, 10'd0, 3'd0);
        apply(2'b10, 10'd0, 3'd0);
        check("R6 restart", therm(55), therm(0), 1'b1);

        // R6 saturation above full scale
        apply(2'b10, 10'd1023, 3'd0);
        check("R6 overshoot", therm(63), therm(63), 1'b0);

        // R2 reset mid-run
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk) #1 check("R2 mid reset", '0, '0, 1'b0);

        done = 1'b1;
        finish_run();
    end
endmodule